// File: doc/BRIEF.md
# Charge-Pump Control and Lock-Pin Test Multiplexer

This block sits between a PLL's phase detector and its analog charge pump. It takes a three-bit test-mode setting and decides the pump drive each cycle. The pump can follow the detector's up and down pulses. It can also be forced off, forced to sink or forced to source. In the automatic switching mode it lowers the pump current once the loop reports lock, and it flags that condition on an active-low status output.

The same mode setting picks what the lock pin carries. In the normal and forced-pump modes the pin shows the in-lock indication. In the two routing modes it shows either the reference tick or a half-rate copy of the divided-VCO pulse train. The block also holds the reference divider, which has three ratios selected by a two-bit field. The divider restarts cleanly whenever that field changes. A further output tells the converter path that its result cannot be used while a test mode is active.

The mode setting is captured into a register on every clock edge. During reset that register holds automatic switching off, normal operation.

Top module: `cp_test_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, the mode register holds code 001. The pump then follows the detector, `pump_hi` equals `cur_hi_req`, `auto_low_n` is 1, `lock_out` equals `in_lock`, and `ref_tick` is 0.
- R2: In mode codes 000, 001, 110 and 111, `pump_src` equals `pd_up & ~pd_dn` and `pump_snk` equals `pd_dn & ~pd_up`. When both pulses are present at once, neither output is asserted.
- R3: In mode 000 with `in_lock`=1, `pump_hi` is 0 and `auto_low_n` is 0. In every other case `pump_hi` equals `cur_hi_req` and `auto_low_n` is 1.
- R4: In mode codes 010 and 011, `pump_src` and `pump_snk` are both 0, whatever the detector inputs are.
- R5: Mode 100 gives `pump_snk`=1 and `pump_src`=0. Mode 101 gives `pump_src`=1 and `pump_snk`=0. In both, the detector inputs are ignored. `pump_src` and `pump_snk` are never 1 together.
- R6: In mode codes 000 through 101, `lock_out` equals `in_lock`.
- R7: In mode 110, `lock_out` equals `ref_tick`.
- R8: In mode 111, `lock_out` shows a toggle register. That register is 0 after reset and inverts on each clock edge at which `vco_pulse` is 1.
- R9: `adc_invalid` equals bit 2 of the registered mode code.
- R10: `ref_tick` is a one-cycle pulse with period N. With `ratio_sel`={bit1,bit0}, bit0=0 gives N=640, 01 gives N=1024 and 11 gives N=512.
- R11: When `ratio_sel` differs from the captured ratio, the counter restarts from zero at that edge and gives no tick there. The first tick then follows N edges later, so it appears at the (N+1)-th edge when the capturing edge is counted as the first.
- R12: A mode change written to `test_bits` takes effect after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_bits | input | 3 | Mode code, registered every cycle |
| ratio_sel | input | 2 | Reference divider ratio select |
| in_lock | input | 1 | Loop-locked indication |
| pd_up | input | 1 | Phase-detector up pulse |
| pd_dn | input | 1 | Phase-detector down pulse |
| cur_hi_req | input | 1 | Programmed high-current request |
| vco_pulse | input | 1 | Divided-VCO pulse, one cycle wide |
| pump_src | output | 1 | Pump source enable |
| pump_snk | output | 1 | Pump sink enable |
| pump_hi | output | 1 | Pump high-current select |
| auto_low_n | output | 1 | Active-low flag: automatic low current in force |
| lock_out | output | 1 | Lock pin output |
| adc_invalid | output | 1 | Converter result unusable (test mode) |
| ref_tick | output | 1 | Divided reference pulse |

## Verification
A ratio change and the divider's terminal count can land on the same edge. In that case the restart must win: no tick is produced, and a full new period follows. The bench provokes this by waiting for a tick and then counting exactly N-1 further edges. It applies the new ratio just before the edge at which the counter would have wrapped. It then checks that no tick appears on that edge and that the next tick arrives at the (N+1)-th edge counted from it.

// File: rtl/cp_pkg.sv
package cp_pkg;

  typedef enum logic [2:0] {
    MODE_AUTO_ON  = 3'b000,
    MODE_AUTO_OFF = 3'b001,
    MODE_OFF_A    = 3'b010,
    MODE_OFF_B    = 3'b011,
    MODE_SINK     = 3'b100,
    MODE_SOURCE   = 3'b101,
    MODE_SHOW_REF = 3'b110,
    MODE_SHOW_VCO = 3'b111
  } cp_mode_e;

  typedef struct packed {
    logic auto_sw;
    logic force_off;
    logic force_snk;
    logic force_src;
    logic route_ref;
    logic route_vco;
    logic test_act;
  } cp_flags_t;

endpackage

// File: rtl/cp_mode_dec.sv
module cp_mode_dec
  import cp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] test_bits,
  output cp_flags_t  flags
);
  cp_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = cp_mode_e'(test_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_AUTO_OFF;
    else        mode_q <= mode_d;
  end

  always_comb begin
    flags           = '0;
    flags.test_act  = mode_q[2];
    unique case (mode_q)
      MODE_AUTO_ON:          flags.auto_sw   = 1'b1;
      MODE_OFF_A, MODE_OFF_B: flags.force_off = 1'b1;
      MODE_SINK:             flags.force_snk = 1'b1;
      MODE_SOURCE:           flags.force_src = 1'b1;
      MODE_SHOW_REF:         flags.route_ref = 1'b1;
      MODE_SHOW_VCO:         flags.route_vco = 1'b1;
      default:               ;
    endcase
  end

  assert_one_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flags.force_off, flags.force_snk, flags.force_src, flags.auto_sw}));
endmodule

// File: rtl/cp_pump_ovr.sv
module cp_pump_ovr
  import cp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cp_flags_t flags,
  input  logic      in_lock,
  input  logic      pd_up,
  input  logic      pd_dn,
  input  logic      cur_hi_req,
  output logic      pump_src,
  output logic      pump_snk,
  output logic      pump_hi,
  output logic      auto_low_n
);
  logic low_forced;

  always_comb begin
    low_forced = flags.auto_sw & in_lock;
    auto_low_n = ~low_forced;
    pump_hi    = cur_hi_req & ~low_forced;
    if (flags.force_off) begin
      pump_src = 1'b0;
      pump_snk = 1'b0;
    end else if (flags.force_snk) begin
      pump_src = 1'b0;
      pump_snk = 1'b1;
    end else if (flags.force_src) begin
      pump_src = 1'b1;
      pump_snk = 1'b0;
    end else begin
      pump_src = pd_up & ~pd_dn;
      pump_snk = pd_dn & ~pd_up;
    end
  end

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_src && pump_snk));
  assert_off_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flags.force_off |-> (!pump_src && !pump_snk));
  assert_low_when_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.auto_sw && in_lock) |-> (!pump_hi && !auto_low_n));
endmodule

// File: rtl/cp_ref_div.sv
module cp_ref_div #(
  parameter int DIV_DFLT   = 640,
  parameter int DIV_WIDE   = 1024,
  parameter int DIV_NARROW = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ratio_sel,
  output logic       ref_tick
);
  localparam int DIV_MAX0 = (DIV_DFLT > DIV_WIDE) ? DIV_DFLT : DIV_WIDE;
  localparam int DIV_MAX  = (DIV_MAX0 > DIV_NARROW) ? DIV_MAX0 : DIV_NARROW;
  localparam int CNT_W    = $clog2(DIV_MAX);

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic [1:0]       ratio_q, ratio_d;
  logic             tick_q, tick_d;
  logic             restart;

  always_comb begin
    unique case (ratio_q)
      2'b01:   limit = CNT_W'(DIV_WIDE - 1);
      2'b11:   limit = CNT_W'(DIV_NARROW - 1);
      default: limit = CNT_W'(DIV_DFLT - 1);
    endcase
  end

  always_comb begin
    restart = (ratio_sel != ratio_q);
    ratio_d = ratio_q;
    tick_d  = 1'b0;
    if (restart) begin
      ratio_d = ratio_sel;
      cnt_d   = '0;
    end else if (cnt_q == limit) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= 2'b00;
      tick_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      tick_q  <= tick_d;
    end
  end

  assign ref_tick = tick_q;

  assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && !ref_tick));
  assert_tick_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |=> !ref_tick);
  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DIV_MAX - 1));
endmodule

// File: rtl/cp_lock_mux.sv
module cp_lock_mux
  import cp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cp_flags_t flags,
  input  logic      in_lock,
  input  logic      ref_tick,
  input  logic      vco_pulse,
  output logic      lock_out
);
  logic half_q, half_d;

  always_comb begin
    half_d = half_q;
    if (vco_pulse) half_d = ~half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_d;
  end

  always_comb begin
    if (flags.route_ref)      lock_out = ref_tick;
    else if (flags.route_vco) lock_out = half_q;
    else                      lock_out = in_lock;
  end

  assert_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vco_pulse |=> (half_q != $past(half_q)));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !vco_pulse |=> $stable(half_q));
endmodule

// File: rtl/cp_test_ctrl.sv
module cp_test_ctrl
  import cp_pkg::*;
#(
  parameter int DIV_DFLT   = 640,
  parameter int DIV_WIDE   = 1024,
  parameter int DIV_NARROW = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] test_bits,
  input  logic [1:0] ratio_sel,
  input  logic       in_lock,
  input  logic       pd_up,
  input  logic       pd_dn,
  input  logic       cur_hi_req,
  input  logic       vco_pulse,
  output logic       pump_src,
  output logic       pump_snk,
  output logic       pump_hi,
  output logic       auto_low_n,
  output logic       lock_out,
  output logic       adc_invalid,
  output logic       ref_tick
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  cp_flags_t  flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cp_mode_dec u_mode (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .test_bits (test_bits),
    .flags     (flags)
  );

  cp_pump_ovr u_pump (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .flags      (flags),
    .in_lock    (in_lock),
    .pd_up      (pd_up),
    .pd_dn      (pd_dn),
    .cur_hi_req (cur_hi_req),
    .pump_src   (pump_src),
    .pump_snk   (pump_snk),
    .pump_hi    (pump_hi),
    .auto_low_n (auto_low_n)
  );

  cp_ref_div #(
    .DIV_DFLT   (DIV_DFLT),
    .DIV_WIDE   (DIV_WIDE),
    .DIV_NARROW (DIV_NARROW)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ratio_sel (ratio_sel),
    .ref_tick  (ref_tick)
  );

  cp_lock_mux u_lock (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .flags     (flags),
    .in_lock   (in_lock),
    .ref_tick  (ref_tick),
    .vco_pulse (vco_pulse),
    .lock_out  (lock_out)
  );

  assign adc_invalid = flags.test_act;

  assert_adc_flag_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    adc_invalid |-> !auto_low_n == 1'b0);
endmodule

// File: tb/cp_test_ctrl_test.sv
module cp_test_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] test_bits;
  logic [1:0] ratio_sel;
  logic       in_lock, pd_up, pd_dn, cur_hi_req, vco_pulse;
  logic       pump_src, pump_snk, pump_hi, auto_low_n, lock_out, adc_invalid, ref_tick;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cp_test_ctrl uut (
    .clk(clk), .rst_n(rst_n), .test_bits(test_bits), .ratio_sel(ratio_sel),
    .in_lock(in_lock), .pd_up(pd_up), .pd_dn(pd_dn), .cur_hi_req(cur_hi_req),
    .vco_pulse(vco_pulse), .pump_src(pump_src), .pump_snk(pump_snk),
    .pump_hi(pump_hi), .auto_low_n(auto_low_n), .lock_out(lock_out),
    .adc_invalid(adc_invalid), .ref_tick(ref_tick)
  );

  // {mode[2:0], in_lock, up, dn, hi_req} -> {src, snk, hi, lock, auto_low_n, adc_invalid}
  // Covers R2 R3 R4 R5 R6 R9
  localparam logic [12:0] VEC [NVEC] = '{
    {3'b000, 4'b1101, 6'b100100},
    {3'b000, 4'b0101, 6'b101010},
    {3'b000, 4'b1011, 6'b010100},
    {3'b000, 4'b0111, 6'b001010},
    {3'b001, 4'b1101, 6'b101110},
    {3'b001, 4'b1010, 6'b010110},
    {3'b010, 4'b1101, 6'b001110},
    {3'b011, 4'b0011, 6'b001010},
    {3'b100, 4'b0101, 6'b011011},
    {3'b100, 4'b1000, 6'b010111},
    {3'b101, 4'b0011, 6'b101011},
    {3'b101, 4'b1110, 6'b100111}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // counts edges (starting with the next one) until ref_tick is seen
  task automatic edges_to_tick(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!ref_tick && n < 3000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; test_bits = 3'b000; ratio_sel = 2'b00;
    in_lock = 1'b1; pd_up = 1'b1; pd_dn = 1'b0; cur_hi_req = 1'b1; vco_pulse = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset mode is auto-off normal even though 000 is applied
    check("R1 src", pump_src, 1'b1);
    check("R1 hi", pump_hi, 1'b1);
    check("R1 auto_low_n", auto_low_n, 1'b1);
    check("R1 lock_out", lock_out, 1'b1);
    check("R1 ref_tick", ref_tick, 1'b0);
    check("R1 adc_invalid", adc_invalid, 1'b0);

    @(negedge clk) rst_n = 1'b1;
    repeat (3) step();
    // R12: 000 now captured
    check("R12 mode captured hi", pump_hi, 1'b0);

    // R10: first tick after reset release, then periods per ratio
    edges_to_tick(n);
    edges_to_tick(n);
    check("R10 period 640", n, 640);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {test_bits, in_lock, pd_up, pd_dn, cur_hi_req} = VEC[i][12:6];
      step();
      check($sformatf("R2 R4 R5 src vec %0d", i), pump_src, VEC[i][5]);
      check($sformatf("R2 R4 R5 snk vec %0d", i), pump_snk, VEC[i][4]);
      check($sformatf("R3 hi vec %0d", i), pump_hi, VEC[i][3]);
      check($sformatf("R6 lock vec %0d", i), lock_out, VEC[i][2]);
      check($sformatf("R3 auto_low_n vec %0d", i), auto_low_n, VEC[i][1]);
      check($sformatf("R9 adc vec %0d", i), adc_invalid, VEC[i][0]);
    end

    // R7: reference shown on lock pin; R2 pump follows detector in 110
    @(negedge clk);
    test_bits = 3'b110; in_lock = 1'b0; pd_up = 1'b0; pd_dn = 1'b1; cur_hi_req = 1'b1;
    step();
    check("R2 snk in 110", pump_snk, 1'b1);
    check("R9 adc in 110", adc_invalid, 1'b1);
    check("R3 hi in 110 unlocked", pump_hi, 1'b1);
    begin
      int bad = 0;
      int seen = 0;
      for (int k = 0; k < 700; k++) begin
        step();
        if (lock_out !== ref_tick) bad++;
        if (ref_tick) seen++;
      end
      check("R7 lock_out follows ref_tick", bad, 0);
      check("R7 tick seen on lock pin", seen, 1);
    end

    // R8: half-rate divided VCO
    @(negedge clk);
    test_bits = 3'b111;
    step();
    check("R8 toggle reset value", lock_out, 1'b0);
    @(negedge clk) vco_pulse = 1'b1;
    @(negedge clk) vco_pulse = 1'b0;
    #1 check("R8 toggle after 1 pulse", lock_out, 1'b1);
    repeat (3) step();
    check("R8 holds without pulse", lock_out, 1'b1);
    @(negedge clk) vco_pulse = 1'b1;
    @(negedge clk) vco_pulse = 1'b0;
    #1 check("R8 toggle after 2 pulses", lock_out, 1'b0);

    // R10 other ratios, R11 restart on change
    @(negedge clk) ratio_sel = 2'b01;
    edges_to_tick(n);
    check("R11 first tick after change to 1024", n, 1025);
    edges_to_tick(n);
    check("R10 period 1024", n, 1024);
    @(negedge clk) ratio_sel = 2'b11;
    edges_to_tick(n);
    check("R11 first tick after change to 512", n, 513);
    edges_to_tick(n);
    check("R10 period 512", n, 512);
    @(negedge clk) ratio_sel = 2'b10;
    edges_to_tick(n);
    check("R11 first tick after change to 10", n, 641);
    edges_to_tick(n);
    check("R10 period 640 with bit1 set", n, 640);

    // R11: change lands on the terminal-count edge
    repeat (639) step();
    @(negedge clk) ratio_sel = 2'b11;
    step();
    check("R11 no tick on colliding edge", ref_tick, 1'b0);
    n = 1;
    while (!ref_tick && n < 3000) begin
      step();
      n++;
    end
    check("R11 full period after collision", n, 513);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule